// File: doc/BRIEF.md
# Page-Packed Framebuffer Raster Scanout

This block turns a byte framebuffer that stores pixels in vertical groups into a raster pixel stream. The framebuffer has 132 byte columns and 8 pages. Each byte covers eight lines of one column, and its least significant bit is the top line. A 96-column by 16-line window is cut from this store. The window starts 36 byte columns in, and its first line is set by a programmable start line that wraps modulo 64. Every source pixel is widened to a 4-by-4 block, so one frame is 384 pixels by 64 lines. The block issues reads on a synchronous framebuffer port with one cycle of read latency. It emits one pixel per clock, with a valid strobe, a first-pixel-of-line marker and a last-pixel-of-frame marker.

A frame starts only when two things are true: the start trigger fires and the external redraw flag is set. The block acts only as the reader of that flag. When the frame completes it raises a one-cycle clear request, and the owner of the flag clears it. Two colour controls shape the output. One forces every pixel on. The other inverts the sense of the stored bits. The start line and both colour controls are captured at the moment a frame starts.

Top module: `page_scanout`

## Requirements
- R1: During synchronous reset and in the cycle after it, the outputs pix_valid_o, frame_end_o and fb_rd_en_o are low. A reset in the middle of a frame stops the frame.
- R2: A start pulse that is accepted while redraw_i is high produces exactly 384 x 64 = 24576 valid pixels. There are no idle cycles between the first pixel and the last. fb_rd_en_o is high only while a frame is being read.
- R3: A start pulse while redraw_i is low produces no valid pixel and no framebuffer read.
- R4: Output line L (0..63) comes from source line s = (L/4 + start_line) mod 64. The byte read is at address 132*(s>>3) + 36 + P/4, where P (0..383) is the pixel index in the line. The pixel bit is bit (s & 7) of that byte, and bit 0 is the top line of a page.
- R5: When all-on and inverse are both clear, the output pixel equals the stored bit.
- R6: When all-on is clear and inverse is set, the output pixel is the complement of the stored bit.
- R7: When all-on is set, every output pixel is 1, whatever inverse and the stored data hold.
- R8: Each source pixel fills 4 consecutive pixels in a line. Each source line fills 4 consecutive output lines.
- R9: line_start_o is high with the first pixel of each output line, which gives 64 pulses per frame. It is high on no other pixel.
- R10: frame_end_o is high with pixel 24575 only, and redraw_clr_o pulses once in that same cycle. pix_valid_o is low in the following cycle.
- R11: A start pulse during a frame is ignored. Changes to the start line, all-on and inverse after a frame has started do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start trigger |
| redraw_i | input | 1 | Redraw-pending flag, owned outside the block |
| start_line_i | input | 6 | First source line of the window |
| all_on_i | input | 1 | Force all pixels on |
| inverse_i | input | 1 | Invert the stored pixel sense |
| fb_rd_en_o | output | 1 | Framebuffer read enable |
| fb_rd_addr_o | output | 11 | Framebuffer byte address |
| fb_rd_data_i | input | 8 | Read data, valid one cycle after the address |
| pix_o | output | 1 | Pixel value |
| pix_valid_o | output | 1 | Pixel strobe |
| line_start_o | output | 1 | First pixel of an output line |
| frame_end_o | output | 1 | Last pixel of the frame |
| redraw_clr_o | output | 1 | Request to clear the redraw flag |

## Verification
The bench builds the block with its default parameters: 132 columns, 8 pages, an offset of 36, a 96 x 16 window and 4x magnification. It compares every pixel of full frames against a model of the framebuffer. A start line of 60 makes the window wrap from the last page back to page 0, which tests the modulo-64 wrap and the address computation at the top of the store. Other frames use an odd start line with inversion, and all-on with inversion also set, so each colour rule and a bit position in the middle of a page are checked with real data.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_e;

  // colour controls, latched at frame start and carried down the pipe
  typedef struct packed {
    logic all_on;
    logic inverse;
  } color_mode_t;

  // per-beat qualifiers travelling alongside the read address
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } beat_tag_t;

endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int WIN_COLS = 96,
  parameter int WIN_ROWS = 16,
  parameter int MAG      = 4,
  parameter int COL_W    = 7,
  parameter int ROW_W    = 4,
  parameter int MAG_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             redraw_i,
  input  logic             hold_i,
  output logic             run_o,
  output logic             capture_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             first_o,
  output logic             last_o
);

  scan_state_e      st;
  logic [MAG_W-1:0] hx;
  logic [MAG_W-1:0] vy;
  logic [COL_W-1:0] x;
  logic [ROW_W-1:0] y;

  logic hx_end, x_end, vy_end, y_end;

  assign hx_end = (hx == MAG_W'(MAG - 1));
  assign vy_end = (vy == MAG_W'(MAG - 1));
  assign x_end  = (x == COL_W'(WIN_COLS - 1));
  assign y_end  = (y == ROW_W'(WIN_ROWS - 1));

  // a frame is accepted only when idle, flagged, and the previous tail has drained
  assign capture_o = (st == SC_IDLE) && start_i && redraw_i && !hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SC_IDLE;
      hx <= '0;
      vy <= '0;
      x  <= '0;
      y  <= '0;
    end else begin
      case (st)
        SC_IDLE: begin
          if (capture_o) st <= SC_RUN;
        end
        SC_RUN: begin
          hx <= hx_end ? '0 : hx + 1'b1;
          if (hx_end) begin
            x <= x_end ? '0 : x + 1'b1;
            if (x_end) begin
              vy <= vy_end ? '0 : vy + 1'b1;
              if (vy_end) begin
                y <= y_end ? '0 : y + 1'b1;
                if (y_end) st <= SC_IDLE;
              end
            end
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  assign run_o   = (st == SC_RUN);
  assign col_o   = x;
  assign row_o   = y;
  assign first_o = run_o && (hx == '0) && (x == '0);
  assign last_o  = run_o && hx_end && x_end && vy_end && y_end;

endmodule

// File: rtl/scan_addr.sv
module scan_addr
  import scan_pkg::*;
#(
  parameter int FB_COLS = 132,
  parameter int COL_OFS = 36,
  parameter int COL_W   = 7,
  parameter int ROW_W   = 4,
  parameter int LINE_W  = 6,
  parameter int BIT_W   = 3,
  parameter int ADDR_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  beat_tag_t         tag_i,
  input  color_mode_t       mode_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [LINE_W-1:0] start_line_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [BIT_W-1:0]  bit_o,
  output beat_tag_t         tag_o,
  output color_mode_t       mode_o
);

  logic [LINE_W-1:0] src_line;
  logic [ADDR_W-1:0] page_base;
  logic [ADDR_W-1:0] byte_addr;

  // truncation to LINE_W gives the wrap through the page stack
  assign src_line  = LINE_W'(row_i) + start_line_i;
  assign page_base = ADDR_W'(src_line[LINE_W-1:BIT_W]) * ADDR_W'(FB_COLS);
  assign byte_addr = page_base + ADDR_W'(COL_OFS) + ADDR_W'(col_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_o <= 1'b0;
      tag_o   <= '0;
    end else begin
      rd_en_o <= tag_i.valid;
      tag_o   <= tag_i;
    end
  end

  always_ff @(posedge clk) begin
    rd_addr_o <= byte_addr;
    bit_o     <= src_line[BIT_W-1:0];
    mode_o    <= mode_i;
  end

endmodule

// File: rtl/scan_color.sv
module scan_color
  import scan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  beat_tag_t         tag_i,
  input  color_mode_t       mode_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              pix_o,
  output logic              valid_o,
  output logic              first_o,
  output logic              last_o
);

  beat_tag_t        tag_q;
  color_mode_t      mode_q;
  logic [BIT_W-1:0] bit_q;
  logic             raw_bit;

  // align qualifiers with the read data returning one cycle later
  always_ff @(posedge clk) begin
    if (rst) tag_q <= '0;
    else     tag_q <= tag_i;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_i;
    bit_q  <= bit_i;
  end

  assign raw_bit = data_i[bit_q];
  assign busy_o  = tag_q.valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o   <= 1'b0;
      valid_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= tag_q.valid;
      first_o <= tag_q.valid && tag_q.first;
      last_o  <= tag_q.valid && tag_q.last;
      pix_o   <= tag_q.valid && (mode_q.all_on || (raw_bit ^ mode_q.inverse));
    end
  end

endmodule

// File: rtl/page_scanout.sv
module page_scanout
  import scan_pkg::*;
#(
  parameter int FB_COLS  = 132,
  parameter int FB_PAGES = 8,
  parameter int DATA_W   = 8,
  parameter int WIN_COLS = 96,
  parameter int WIN_ROWS = 16,
  parameter int COL_OFS  = 36,
  parameter int MAG      = 4,
  localparam int LINE_W  = $clog2(FB_PAGES * DATA_W),
  localparam int ADDR_W  = $clog2(FB_COLS * FB_PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              redraw_i,
  input  logic [LINE_W-1:0] start_line_i,
  input  logic              all_on_i,
  input  logic              inverse_i,
  output logic              fb_rd_en_o,
  output logic [ADDR_W-1:0] fb_rd_addr_o,
  input  logic [DATA_W-1:0] fb_rd_data_i,
  output logic              pix_o,
  output logic              pix_valid_o,
  output logic              line_start_o,
  output logic              frame_end_o,
  output logic              redraw_clr_o
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int COL_W = $clog2(WIN_COLS);
  localparam int ROW_W = $clog2(WIN_ROWS);
  localparam int MAG_W = (MAG > 1) ? $clog2(MAG) : 1;

  logic              seq_run;
  logic              seq_capture;
  logic [COL_W-1:0]  seq_col;
  logic [ROW_W-1:0]  seq_row;
  logic              seq_first;
  logic              seq_last;
  logic              pipe_hold;
  logic              color_busy;

  logic [LINE_W-1:0] start_line_q;
  color_mode_t       mode_q;

  beat_tag_t         seq_tag;
  beat_tag_t         rd_tag;
  color_mode_t       rd_mode;
  logic [BIT_W-1:0]  rd_bit;

  // frame settings are frozen when a frame is accepted
  always_ff @(posedge clk) begin
    if (rst) begin
      start_line_q <= '0;
      mode_q       <= '0;
    end else if (seq_capture) begin
      start_line_q   <= start_line_i;
      mode_q.all_on  <= all_on_i;
      mode_q.inverse <= inverse_i;
    end
  end

  assign pipe_hold = rd_tag.valid || color_busy || pix_valid_o;

  scan_seq #(
    .WIN_COLS (WIN_COLS),
    .WIN_ROWS (WIN_ROWS),
    .MAG      (MAG),
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .MAG_W    (MAG_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .redraw_i  (redraw_i),
    .hold_i    (pipe_hold),
    .run_o     (seq_run),
    .capture_o (seq_capture),
    .col_o     (seq_col),
    .row_o     (seq_row),
    .first_o   (seq_first),
    .last_o    (seq_last)
  );

  assign seq_tag.valid = seq_run;
  assign seq_tag.first = seq_first;
  assign seq_tag.last  = seq_last;

  scan_addr #(
    .FB_COLS (FB_COLS),
    .COL_OFS (COL_OFS),
    .COL_W   (COL_W),
    .ROW_W   (ROW_W),
    .LINE_W  (LINE_W),
    .BIT_W   (BIT_W),
    .ADDR_W  (ADDR_W)
  ) u_addr (
    .clk          (clk),
    .rst          (rst),
    .tag_i        (seq_tag),
    .mode_i       (mode_q),
    .col_i        (seq_col),
    .row_i        (seq_row),
    .start_line_i (start_line_q),
    .rd_en_o      (fb_rd_en_o),
    .rd_addr_o    (fb_rd_addr_o),
    .bit_o        (rd_bit),
    .tag_o        (rd_tag),
    .mode_o       (rd_mode)
  );

  scan_color #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_color (
    .clk     (clk),
    .rst     (rst),
    .tag_i   (rd_tag),
    .mode_i  (rd_mode),
    .bit_i   (rd_bit),
    .data_i  (fb_rd_data_i),
    .busy_o  (color_busy),
    .pix_o   (pix_o),
    .valid_o (pix_valid_o),
    .first_o (line_start_o),
    .last_o  (frame_end_o)
  );

  // the completion marker doubles as the flag-clear request
  assign redraw_clr_o = frame_end_o;

endmodule

// File: rtl/scan_chk.sv
module scan_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic redraw_i,
  input logic run_i,
  input logic fb_rd_en_i,
  input logic pix_valid_i,
  input logic line_start_i,
  input logic frame_end_i
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pix_valid_i && !fb_rd_en_i && !frame_end_i));

  // R3
  no_flag_no_run_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && start_i && !redraw_i) |=> !run_i);

  // R2
  gapless_stream_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid_i && !frame_end_i) |=> pix_valid_i);

  // R9
  line_mark_valid_chk: assert property (@(posedge clk) disable iff (rst)
    line_start_i |-> pix_valid_i);

  // R10
  end_mark_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_i |-> pix_valid_i);

  // R10
  end_then_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_i |=> !pix_valid_i);

endmodule

bind page_scanout scan_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .redraw_i     (redraw_i),
  .run_i        (seq_run),
  .fb_rd_en_i   (fb_rd_en_o),
  .pix_valid_i  (pix_valid_o),
  .line_start_i (line_start_o),
  .frame_end_i  (frame_end_o)
);

// File: tb/tb_page_scanout.sv
module tb_page_scanout;

  localparam int FB_COLS  = 132;
  localparam int FB_PAGES = 8;
  localparam int FB_SIZE  = FB_COLS * FB_PAGES;
  localparam int OFS      = 36;
  localparam int OUT_W    = 384;
  localparam int OUT_H    = 64;
  localparam int FRAME_PX = OUT_W * OUT_H;

  // {redraw set, start line, all-on, inverse, frame expected}
  localparam logic [9:0] CFG [5] = '{
    {1'b1, 6'd0,  1'b0, 1'b0, 1'b1},
    {1'b1, 6'd5,  1'b0, 1'b1, 1'b1},
    {1'b1, 6'd60, 1'b0, 1'b0, 1'b1},
    {1'b0, 6'd9,  1'b0, 1'b0, 1'b0},
    {1'b1, 6'd13, 1'b1, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       redraw;
  logic       redraw_set = 1'b0;
  logic [5:0] start_line_i = '0;
  logic       all_on_i = 1'b0;
  logic       inverse_i = 1'b0;
  logic       fb_rd_en_o;
  logic [10:0] fb_rd_addr_o;
  logic [7:0] fb_rd_data_i;
  logic       pix_o, pix_valid_o, line_start_o, frame_end_o, redraw_clr_o;

  logic [7:0] fb [FB_SIZE];

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  page_scanout dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .redraw_i     (redraw),
    .start_line_i (start_line_i),
    .all_on_i     (all_on_i),
    .inverse_i    (inverse_i),
    .fb_rd_en_o   (fb_rd_en_o),
    .fb_rd_addr_o (fb_rd_addr_o),
    .fb_rd_data_i (fb_rd_data_i),
    .pix_o        (pix_o),
    .pix_valid_o  (pix_valid_o),
    .line_start_o (line_start_o),
    .frame_end_o  (frame_end_o),
    .redraw_clr_o (redraw_clr_o)
  );

  // synchronous framebuffer, one cycle of read latency
  always @(posedge clk) begin
    if (fb_rd_en_o) fb_rd_data_i <= fb[fb_rd_addr_o];
  end

  // redraw flag owner
  always @(posedge clk) begin
    if (rst)               redraw <= 1'b0;
    else if (redraw_set)   redraw <= 1'b1;
    else if (redraw_clr_o) redraw <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_pix(int k, int sl, bit ao, bit inv);
    int oy, ox, line, addr;
    logic b;
    oy   = k / OUT_W;
    ox   = k % OUT_W;
    line = (oy / 4 + sl) % 64;
    addr = FB_COLS * (line / 8) + OFS + ox / 4;
    b    = fb[addr][line % 8];
    if (ao) return 1'b1;
    return inv ? ~b : b;
  endfunction

  task automatic run_row(input logic [9:0] row);
    bit         en, ao, inv, expf;
    int         sl, k, gaps, mism, ls_cnt, ls_bad, fe_idx, fe_cnt, clr_cnt, clr_bad, rd_cnt, limit;
    bit         seen;
    string      ctag;
    en   = row[9];
    sl   = int'(row[8:3]);
    ao   = row[2];
    inv  = row[1];
    expf = row[0];
    ctag = ao ? "R7" : (inv ? "R6" : "R5");
    k = 0; gaps = 0; mism = 0; ls_cnt = 0; ls_bad = 0; fe_idx = -1; fe_cnt = 0;
    clr_cnt = 0; clr_bad = 0; rd_cnt = 0; seen = 0;
    limit = expf ? FRAME_PX + 200 : 300;

    @(negedge clk);
    start_line_i = 6'(sl); all_on_i = ao; inverse_i = inv; redraw_set = en;
    @(negedge clk);
    redraw_set = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // scramble the settings after acceptance (R11)
    start_line_i = ~6'(sl); all_on_i = ~ao; inverse_i = ~inv;

    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (n == 1000) start_i = 1'b1;
      if (n == 1001) start_i = 1'b0;
      if (fb_rd_en_o) rd_cnt++;
      if (redraw_clr_o) begin
        clr_cnt++;
        if (!frame_end_o) clr_bad++;
      end
      if (pix_valid_o) begin
        seen = 1;
        if (pix_o !== exp_pix(k, sl, ao, inv)) begin
          if (mism == 0) $display("  first pixel mismatch at index %0d", k);
          mism++;
        end
        if (line_start_o) ls_cnt++;
        if (line_start_o != ((k % OUT_W) == 0)) ls_bad++;
        if (frame_end_o) begin
          fe_cnt++;
          fe_idx = k;
        end
        k++;
      end else if (seen && fe_cnt == 0) begin
        gaps++;
      end
      if (fe_cnt != 0) break;
    end

    if (expf) begin
      chk(k == FRAME_PX, "R2 pixel count", k, FRAME_PX);
      chk(gaps == 0, "R2 idle cycles inside frame", gaps, 0);
      chk(mism == 0, $sformatf("R4 R8 %s pixel mismatches", ctag), mism, 0);
      chk(ls_cnt == OUT_H && ls_bad == 0, "R9 line start pulses", ls_cnt, OUT_H);
      chk(fe_cnt == 1 && fe_idx == FRAME_PX - 1, "R10 frame end index", fe_idx, FRAME_PX - 1);
      chk(clr_cnt == 1 && clr_bad == 0, "R10 redraw clear pulses", clr_cnt, 1);
      chk(k == FRAME_PX && mism == 0, "R11 restart and setting changes ignored", mism, 0);
      start_i = 1'b0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (pix_valid_o) gaps++;
      end
      chk(gaps == 0 && redraw == 1'b0, "R10 quiet after frame with flag cleared", gaps, 0);
    end else begin
      chk(k == 0 && rd_cnt == 0, "R3 no output without redraw flag", k + rd_cnt, 0);
    end
  endtask

  initial begin
    for (int a = 0; a < FB_SIZE; a++)
      fb[a] = 8'((a * 29 + (a >> 4) * 7 + 3) ^ (a >> 2));

    repeat (4) @(negedge clk);
    chk(pix_valid_o == 1'b0 && fb_rd_en_o == 1'b0 && frame_end_o == 1'b0,
        "R1 outputs during reset", int'(pix_valid_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pix_valid_o == 1'b0 && line_start_o == 1'b0 && redraw_clr_o == 1'b0,
        "R1 outputs after reset", int'(pix_valid_o), 0);

    foreach (CFG[i]) run_row(CFG[i]);

    // directed: reset in the middle of a frame
    begin
      int act;
      act = 0;
      @(negedge clk);
      start_line_i = '0; all_on_i = 1'b0; inverse_i = 1'b0; redraw_set = 1'b1;
      @(negedge clk);
      redraw_set = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (500) @(negedge clk);
      chk(pix_valid_o == 1'b1, "R2 frame running before reset", int'(pix_valid_o), 1);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int n = 0; n < 50; n++) begin
        @(negedge clk);
        if (pix_valid_o || fb_rd_en_o || frame_end_o) act++;
      end
      chk(act == 0, "R1 reset aborts frame", act, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R2 watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule